// File: doc/BRIEF.md
# Backlight Inverter Control Sequencer

This block drives the digital control pins of a lamp backlight inverter: an enable line, a dimming-mode select line, a low-frequency PWM line for external dimming, and a brightness code for internal dimming. A host gives it a power request, a mode bit and an 8-bit brightness code. The block enforces the required order of these pins. The enable rises only after the inverter supply has been good for a guard time, with the mode select already settled. The mode select never moves while the lamp is lit. Whenever the enable is low, a release flag tells the supply logic when it may safely remove the supply.

In external mode the block makes a PWM wave near 160 Hz. Its period is derived from the system clock frequency, and the duty comes from the brightness code. The dimming input that is not in use is held at ground: the PWM pin stays low in internal mode, and the internal brightness code is zero in external mode. Any brightness below 20 percent is raised to 20 percent. A new duty takes effect only at the start of a PWM period, so no period is ever cut short.

Top module: `bl_seq`

## Requirements
- R1: After reset, lamp_en, mode_ext, pwm_out and int_level are 0, and supply_release is 1.
- R2: lamp_en rises only when lamp_req is 1 and supply_ok has been high on at least GUARD consecutive earlier clock edges, where GUARD = CLK_HZ*GUARD_US/1e6 cycles.
- R3: While lamp_en is low, mode_ext takes the value of mode_req one cycle later. mode_ext is stable on the cycle before lamp_en rises and on the cycle it rises.
- R4: A change of mode_req while lamp_en is high does not change mode_ext. The pending value is applied on the cycle after lamp_en has fallen.
- R5: lamp_en falls on the clock edge after lamp_req or supply_ok goes low.
- R6: supply_release is 1 only when lamp_en has been low for at least GUARD cycles. It is 0 from the edge where lamp_en falls until that count is reached.
- R7: The PWM period is PERIOD = CLK_HZ/PWM_HZ cycles. In external mode with the lamp on, pwm_out is high for the first floor(eff*PERIOD/255) cycles of each period, where eff is the clamped code.
- R8: The effective code eff is max(level_req, 51). Code 51 is 20 percent of 255.
- R9: pwm_out is 0 whenever mode_ext is 0 or lamp_en is 0. int_level is 0 whenever mode_ext is 1 or lamp_en is 0, and otherwise equals eff.
- R10: A change of level_req affects pwm_out only from the next period boundary.
- R11: No output is ever unknown after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Inverter supply is within range |
| lamp_req | input | 1 | Host request to light the lamp |
| mode_req | input | 1 | Host dimming mode: 1 external PWM, 0 internal |
| level_req | input | 8 | Requested brightness code, 255 full |
| lamp_en | output | 1 | Inverter enable |
| mode_ext | output | 1 | Dimming select to inverter: 1 external, 0 internal |
| pwm_out | output | 1 | External dimming PWM |
| int_level | output | 8 | Internal dimming code, grounded when unused |
| supply_release | output | 1 | Supply may be removed |

## Verification
The hardest case to reach is a mode request that changes while the lamp is lit and is then applied after shutdown. To get there, the stimulus first lights the lamp in external mode, flips mode_req and holds it for many cycles while the lamp stays on, and only then drops the power request. The same run shows the release flag staying low for the whole guard window. The clamp and the boundary rule are reached by changing the code in the middle of a period to a value below 20 percent and to full scale. The high cycles are then counted over a whole period window.

// File: rtl/bl_seq_pkg.sv
package bl_seq_pkg;
  // Raise a brightness code to the floor value.
  function automatic logic [7:0] clamp_level(input logic [7:0] code, input int unsigned floor_code);
    if (int'(code) < floor_code) return 8'(floor_code);
    return code;
  endfunction

  // Number of high cycles in one PWM period for a code.
  function automatic longint unsigned high_cycles(input logic [7:0] code, input longint unsigned period);
    return (longint'(code) * period) / 255;
  endfunction
endpackage

// File: rtl/bl_sat_cnt.sv
module bl_sat_cnt #(
  parameter int unsigned LIMIT     = 64,
  parameter bit          INIT_FULL = 1'b0,
  localparam int unsigned W        = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         full
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  assign full = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= INIT_FULL ? TOP : '0;
    else if (clr)    cnt <= '0;
    else if (!full)  cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP); // R6
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int unsigned PERIOD = 400,
  localparam int unsigned CW    = $clog2(PERIOD + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] eff_code,
  input  logic       gate,
  output logic       pwm,
  output logic       wrap
);
  import bl_seq_pkg::*;

  logic [CW-1:0] phase;
  logic [CW-1:0] thr;

  assign wrap = (phase == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      thr   <= '0;
    end else begin
      phase <= wrap ? '0 : phase + 1'b1;
      if (wrap) thr <= CW'(high_cycles(eff_code, longint'(PERIOD)));
    end
  end

  assign pwm = gate && (phase < thr);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase < CW'(PERIOD)); // R7
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> $stable(thr)); // R10
endmodule

// File: rtl/bl_ctrl.sv
module bl_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic lamp_req,
  input  logic mode_req,
  input  logic supply_settled,
  output logic lamp_en,
  output logic mode_ext,
  output logic turn_on
);
  assign turn_on = !lamp_en && lamp_req && supply_ok && supply_settled
                   && (mode_ext == mode_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp_en  <= 1'b0;
      mode_ext <= 1'b0;
    end else begin
      if (lamp_en) lamp_en <= lamp_req && supply_ok;
      else         lamp_en <= turn_on;
      if (!lamp_en) mode_ext <= mode_req;
    end
  end

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lamp_en) && lamp_en |-> $stable(mode_ext)); // R4
  AST_SEL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_en) |-> $stable(mode_ext)); // R3
  AST_ON_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_en) |-> $past(supply_ok) && $past(lamp_req)); // R2
  AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_en && !(lamp_req && supply_ok) |=> !lamp_en); // R5
endmodule

// File: rtl/bl_seq.sv
module bl_seq #(
  parameter longint unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned     PWM_HZ   = 160,
  parameter int unsigned     GUARD_US = 1000,
  parameter int unsigned     MIN_PCT  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       lamp_req,
  input  logic       mode_req,
  input  logic [7:0] level_req,
  output logic       lamp_en,
  output logic       mode_ext,
  output logic       pwm_out,
  output logic [7:0] int_level,
  output logic       supply_release
);
  import bl_seq_pkg::*;

  localparam int unsigned PERIOD   = int'(CLK_HZ / PWM_HZ);
  localparam int unsigned GUARD    = int'((CLK_HZ * GUARD_US) / 1_000_000);
  localparam int unsigned MIN_CODE = (MIN_PCT * 255 + 99) / 100;
  localparam int unsigned GW       = $clog2(GUARD + 1);

  logic [7:0]    eff_code;
  logic [GW-1:0] on_run, off_run;
  logic          settled, off_long, turn_on, pwm_wrap;

  assign eff_code = clamp_level(level_req, MIN_CODE);

  bl_sat_cnt #(.LIMIT(GUARD), .INIT_FULL(1'b0)) u_good_run (
    .clk(clk), .rst_n(rst_n), .clr(!supply_ok), .cnt(on_run), .full(settled));

  bl_sat_cnt #(.LIMIT(GUARD), .INIT_FULL(1'b1)) u_off_run (
    .clk(clk), .rst_n(rst_n), .clr(lamp_en), .cnt(off_run), .full(off_long));

  bl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lamp_req(lamp_req),
    .mode_req(mode_req), .supply_settled(settled), .lamp_en(lamp_en),
    .mode_ext(mode_ext), .turn_on(turn_on));

  bl_pwm_gen #(.PERIOD(PERIOD)) u_pwm (
    .clk(clk), .rst_n(rst_n), .eff_code(eff_code), .gate(lamp_en && mode_ext),
    .pwm(pwm_out), .wrap(pwm_wrap));

  assign int_level      = (lamp_en && !mode_ext) ? eff_code : 8'd0;
  assign supply_release = !lamp_en && off_long;

  AST_EXT_GROUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext |-> !pwm_out); // R9
  AST_INT_GROUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext |-> int_level == 8'd0); // R9
  AST_INT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    int_level != 8'd0 |-> int_level >= 8'(MIN_CODE)); // R8
  AST_RELEASE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    supply_release |-> !lamp_en && off_run == GW'(GUARD)); // R6
  AST_ON_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |-> on_run == GW'(GUARD)); // R2
  AST_NO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({lamp_en, mode_ext, pwm_out, int_level, supply_release})); // R11
endmodule

// File: tb/bl_seq_tb.sv
`timescale 1ns/1ps
module bl_seq_tb;
  localparam longint unsigned CLK_HZ = 64000;
  localparam int P = 400;   // CLK_HZ / 160
  localparam int G = 64;    // 1 ms at CLK_HZ

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, lamp_req = 0, mode_req = 0;
  logic [7:0] level_req = 8'd0;
  logic lamp_en, mode_ext, pwm_out, supply_release;
  logic [7:0] int_level;

  int total = 0, bad = 0;
  bit done = 0;

  bl_seq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lamp_req(lamp_req),
    .mode_req(mode_req), .level_req(level_req), .lamp_en(lamp_en),
    .mode_ext(mode_ext), .pwm_out(pwm_out), .int_level(int_level),
    .supply_release(supply_release));

  always #2.5 clk = ~clk;

  // Behavioural reference: integer state advanced on each edge.
  int m_on, m_sel, m_good, m_off, m_ph, m_high;
  function automatic int eff(input int c); return (c < 51) ? 51 : c; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_sel = 0; m_good = 0; m_off = G; m_ph = 0; m_high = 0;
    end else begin
      int on_n, sel_n, good_n, off_n, ph_n, high_n;
      if (m_on) on_n = (lamp_req && supply_ok) ? 1 : 0;
      else on_n = (lamp_req && supply_ok && m_good >= G && m_sel == mode_req) ? 1 : 0;
      sel_n  = m_on ? m_sel : int'(mode_req);
      good_n = !supply_ok ? 0 : (m_good < G ? m_good + 1 : G);
      off_n  = m_on ? 0 : (m_off < G ? m_off + 1 : G);
      ph_n   = (m_ph == P - 1) ? 0 : m_ph + 1;
      high_n = (m_ph == P - 1) ? (eff(int'(level_req)) * P) / 255 : m_high;
      m_on = on_n; m_sel = sel_n; m_good = good_n; m_off = off_n; m_ph = ph_n; m_high = high_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R5 lamp_en", int'(lamp_en), m_on);
    chk("R3/R4 mode_ext", int'(mode_ext), m_sel);
    chk("R7/R9 pwm_out", int'(pwm_out), (m_on && m_sel && m_ph < m_high) ? 1 : 0);
    chk("R9 int_level", int'(int_level), (m_on && !m_sel) ? eff(int'(level_req)) : 0);
    chk("R6 supply_release", int'(supply_release), (!m_on && m_off >= G) ? 1 : 0);
    chk("R11 no unknown", int'($isunknown({lamp_en, mode_ext, pwm_out, int_level, supply_release})), 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic count_high(input string req, input int exp);
    int h = 0;
    repeat (P) begin @(negedge clk); h += int'(pwm_out); end
    chk(req, h, exp);
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    chk("R1 reset lamp_en", int'(lamp_en), 0);
    chk("R1 reset pwm_out", int'(pwm_out), 0);
    chk("R1 reset int_level", int'(int_level), 0);
    chk("R1 reset release", int'(supply_release), 1);
    rst_n = 1;
    step(1);
    // External mode requested before the supply is good.
    mode_req = 1; level_req = 8'd128; lamp_req = 1;
    step(10);
    supply_ok = 1;
    step(G - 5);
    @(negedge clk); chk("R2 early on", int'(lamp_en), 0);
    step(20);
    @(negedge clk); chk("R2 on after guard", int'(lamp_en), 1);
    chk("R3 mode settled", int'(mode_ext), 1);
    step(P + 5);
    count_high("R7 duty 128", (128 * P) / 255);
    // Below-floor code set mid-period.
    #1 level_req = 8'd10;
    step(P + 3);
    count_high("R8 clamp to 51", (51 * P) / 255);
    #1 level_req = 8'd255;
    step(P / 2);
    step(P);
    count_high("R10 full scale", P);
    // Mode change while lit is held.
    mode_req = 0;
    step(50);
    @(negedge clk); chk("R4 held while on", int'(mode_ext), 1);
    #1 lamp_req = 0;
    step(1);
    @(negedge clk); chk("R5 off next edge", int'(lamp_en), 0);
    chk("R6 release low", int'(supply_release), 0);
    step(1);
    @(negedge clk); chk("R4 applied after off", int'(mode_ext), 0);
    step(G);
    @(negedge clk); chk("R6 release after guard", int'(supply_release), 1);
    // Internal mode.
    #1 level_req = 8'd5; lamp_req = 1;
    step(4);
    @(negedge clk); chk("R9 internal clamp", int'(int_level), 51);
    chk("R9 pwm grounded", int'(pwm_out), 0);
    #1 level_req = 8'd200;
    step(P);
    #1 supply_ok = 0;
    step(1);
    @(negedge clk); chk("R5 supply loss", int'(lamp_en), 0);
    #1 supply_ok = 1;
    step(G / 2);
    @(negedge clk); chk("R2 guard restarts", int'(lamp_en), 0);
    step(G);
    @(negedge clk); chk("R2 relit", int'(lamp_en), 1);
    step(20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule